// File: doc/BRIEF.md
# CAN Controller Main Control and Status Register

This block is the primary control and status byte of a CAN controller. The CPU reaches it over a simple register bus made of a select (address hit), a read strobe, a write strobe and byte-wide write data. Read data is returned in the same cycle as the read strobe.

The byte combines several kinds of bit:

- a sticky received-frame flag, which hardware sets and software clears by writing 1;
- two read-only status bits driven by the protocol engine (receiver busy and bus synchronized);
- three control enables: stop-in-wait, timer and wake-up;
- a sleep request;
- an initialization request.

The protocol engine, the message storage and the real clock gate sit outside the block and are seen only as signals.

A small state machine follows the initialization handshake between the request bit and the engine's acknowledge input. It has four states:

- **RUN**: request 0, acknowledge 0.
- **PEND**: request 1, waiting for acknowledge.
- **HELD**: request 1, acknowledge 1.
- **LEAVE**: request dropped, acknowledge still 1.

The transitions are:

- RUN→PEND when the request is set.
- RUN→HELD or PEND→HELD when request and acknowledge are both 1.
- PEND→RUN when the request is dropped.
- HELD→LEAVE when the request falls while acknowledge stays 1.
- HELD→PEND when acknowledge falls while the request stays 1.
- LEAVE→HELD when the request is set again.
- LEAVE→PEND when the request is set again and acknowledge has dropped.
- Any state→RUN when request and acknowledge are both 0.

HELD and LEAVE make up the locked condition. While locked, the held bits read at reset value and the CPU can change only the initialization request.

Top module: `can_ctrl_status_reg`

## Requirements
- R1: After reset every stored bit is 0, and the state machine is in RUN.
- R2: The received-frame flag (bit 7) is set on the clock edge after a cycle with `rx_frame_ok` high, provided loopback is off and the block is not locked. Once set, it stays set.
- R3: Writing 1 to bit 7 clears the received-frame flag, and writing 0 to bit 7 leaves it unchanged. If a hardware set and a software clear fall in the same cycle, the flag ends up set.
- R4: Bit 6 reads `eng_rx_busy` and bit 4 reads `eng_synced` in the same cycle, and CPU writes to these two bit positions have no effect.
- R5: While `loopback` is high, the received-frame flag is not set and bit 6 reads 0.
- R6: The init state machine follows the RUN/PEND/HELD/LEAVE transitions listed above. The block is locked exactly in HELD and LEAVE.
- R7: While locked, bits 7 to 3 read 0, and the received-frame flag, stop-in-wait and timer enable are cleared. Wake-up enable (bit 2) and sleep request (bit 1) keep their values.
- R8: While locked, a write changes only the init request (bit 0). All other writable bits ignore it.
- R9: Once request and acknowledge are both 0 again, the state returns to RUN and all writable bits accept writes.
- R10: `bus_clk_off` is 1 exactly when stop-in-wait (bit 5) is 1 and `wait_mode` is 1.
- R11: `rd_data` shows the composed byte (bit 7 rx flag, 6 rx busy, 5 stop-in-wait, 4 synced, 3 timer, 2 wake-up, 1 sleep, 0 init request) while `bus_sel` and `bus_rd` are both high. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Address hit for this register |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, valid in the strobe cycle |
| rx_frame_ok | input | 1 | Pulse from the engine: a valid frame was received |
| eng_rx_busy | input | 1 | Engine status: receiver active |
| eng_synced | input | 1 | Engine status: synchronized to the bus |
| loopback | input | 1 | Loopback mode is active |
| init_ack | input | 1 | Engine acknowledge of initialization |
| wait_mode | input | 1 | CPU wait mode is active |
| bus_clk_off | output | 1 | Request to stop the CPU-bus interface clock |
| timer_en | output | 1 | Timer enable towards the engine |
| wake_en | output | 1 | Wake-up enable towards the engine |
| sleep_req | output | 1 | Sleep request towards the engine |
| init_req | output | 1 | Initialization request towards the engine |

## Verification
The bench builds the block with the default `DATA_W` of 8, the only width at which the fixed bit layout is defined. This lets every bit position be checked as a whole byte against a scoreboard. The stimulus drives the handshake through PEND, HELD and LEAVE back to RUN, with writes attempted in each state. It also lines up a hardware frame event with a clearing write in the same cycle, and repeats frame events under loopback.

// File: rtl/can_csr_pkg.sv
package can_csr_pkg;
    localparam int CSR_W   = 8;
    localparam int B_RXF   = 7;
    localparam int B_RXACT = 6;
    localparam int B_SIW   = 5;
    localparam int B_SYNC  = 4;
    localparam int B_TMR   = 3;
    localparam int B_WAKE  = 2;
    localparam int B_SLP   = 1;
    localparam int B_INIT  = 0;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_PEND  = 2'd1,
        ST_HELD  = 2'd2,
        ST_LEAVE = 2'd3
    } init_state_t;
endpackage

// File: rtl/can_csr_init_fsm.sv
module can_csr_init_fsm
    import can_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic ack,
    output logic locked
);
    init_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (req && ack) state_d = ST_HELD;
                else if (req)   state_d = ST_PEND;
            end
            ST_PEND: begin
                if (req && ack) state_d = ST_HELD;
                else if (!req)  state_d = ST_RUN;
            end
            ST_HELD: begin
                if (!req && !ack)     state_d = ST_RUN;
                else if (!req)        state_d = ST_LEAVE;
                else if (!ack)        state_d = ST_PEND;
            end
            ST_LEAVE: begin
                if (!req && !ack)     state_d = ST_RUN;
                else if (req && ack)  state_d = ST_HELD;
                else if (req)         state_d = ST_PEND;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        locked = 1'b0;
        unique case (state_q)
            ST_HELD, ST_LEAVE: locked = 1'b1;
            default:           locked = 1'b0;
        endcase
    end

    // R6
    held_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD) |-> $past(req && ack));

    // R9
    unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !ack) |=> (state_q == ST_RUN) && !locked);
endmodule

// File: rtl/can_csr_rxflag.sv
module can_csr_rxflag (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_ok,
    input  logic loopback,
    input  logic locked,
    input  logic sw_clear,
    output logic flag
);
    logic hw_set;

    assign hw_set = frame_ok && !loopback;

    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (locked)   flag <= 1'b0;
        else if (hw_set)   flag <= 1'b1;
        else if (sw_clear) flag <= 1'b0;
    end

    // R2
    rxf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok && !loopback && !locked) |=> flag);

    // R3
    rxf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !sw_clear && !locked) |=> flag);

    // R5
    rxf_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && loopback) |=> !flag);
endmodule

// File: rtl/can_csr_ctrl_bits.sv
module can_csr_ctrl_bits
    import can_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [CSR_W-1:0] wdata,
    input  logic             locked,
    output logic             siw,
    output logic             tmr,
    output logic             wake,
    output logic             slp,
    output logic             ireq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            siw  <= 1'b0;
            tmr  <= 1'b0;
            wake <= 1'b0;
            slp  <= 1'b0;
        end else if (locked) begin
            siw  <= 1'b0;
            tmr  <= 1'b0;
        end else if (wr_hit) begin
            siw  <= wdata[B_SIW];
            tmr  <= wdata[B_TMR];
            wake <= wdata[B_WAKE];
            slp  <= wdata[B_SLP];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      ireq <= 1'b0;
        else if (wr_hit) ireq <= wdata[B_INIT];
    end

    // R8
    wake_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(wake) && $stable(slp));

    // R7
    timer_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> !tmr && !siw);
endmodule

// File: rtl/can_ctrl_status_reg.sv
module can_ctrl_status_reg
    import can_csr_pkg::*;
#(
    parameter int DATA_W = CSR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rx_frame_ok,
    input  logic              eng_rx_busy,
    input  logic              eng_synced,
    input  logic              loopback,
    input  logic              init_ack,
    input  logic              wait_mode,
    output logic              bus_clk_off,
    output logic              timer_en,
    output logic              wake_en,
    output logic              sleep_req,
    output logic              init_req
);
    localparam int PAD_W = DATA_W - CSR_W;

    logic             wr_hit, rd_hit, locked;
    logic             rxf, siw, tmr, wake, slp, ireq;
    logic [CSR_W-1:0] byte_v;

    assign wr_hit = bus_sel && bus_wr;
    assign rd_hit = bus_sel && bus_rd;

    can_csr_init_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (ireq),
        .ack    (init_ack),
        .locked (locked)
    );

    can_csr_rxflag u_rxf (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_ok (rx_frame_ok),
        .loopback (loopback),
        .locked   (locked),
        .sw_clear (wr_hit && wr_data[B_RXF]),
        .flag     (rxf)
    );

    can_csr_ctrl_bits u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_hit),
        .wdata  (wr_data[CSR_W-1:0]),
        .locked (locked),
        .siw    (siw),
        .tmr    (tmr),
        .wake   (wake),
        .slp    (slp),
        .ireq   (ireq)
    );

    always_comb begin
        byte_v          = '0;
        byte_v[B_RXF]   = rxf && !locked;
        byte_v[B_RXACT] = eng_rx_busy && !loopback && !locked;
        byte_v[B_SIW]   = siw && !locked;
        byte_v[B_SYNC]  = eng_synced && !locked;
        byte_v[B_TMR]   = tmr && !locked;
        byte_v[B_WAKE]  = wake;
        byte_v[B_SLP]   = slp;
        byte_v[B_INIT]  = ireq;
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign rd_data = rd_hit ? {{PAD_W{1'b0}}, byte_v} : '0;
        end else begin : g_nopad
            assign rd_data = rd_hit ? byte_v : '0;
        end
    endgenerate

    assign bus_clk_off = siw && !locked && wait_mode;
    assign timer_en    = tmr && !locked;
    assign wake_en     = wake;
    assign sleep_req   = slp;
    assign init_req    = ireq;

    // R7
    held_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && rd_hit) |-> (rd_data[7:3] == 5'd0));

    // R10
    clk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_mode |-> !bus_clk_off);

    // R11
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> (rd_data == '0));

    // R5
    loop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loopback && rd_hit) |-> !rd_data[6]);
endmodule

// File: tb/can_ctrl_status_reg_bench.sv
`timescale 1ns/1ps
module can_ctrl_status_reg_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 0, bus_rd = 0, bus_wr = 0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       rx_frame_ok = 0, eng_rx_busy = 0, eng_synced = 0;
    logic       loopback = 0, init_ack = 0, wait_mode = 0;
    logic       bus_clk_off, timer_en, wake_en, sleep_req, init_req;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    can_ctrl_status_reg u_can_ctrl_status_reg (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .wr_data(wr_data), .rd_data(rd_data),
        .rx_frame_ok(rx_frame_ok), .eng_rx_busy(eng_rx_busy),
        .eng_synced(eng_synced), .loopback(loopback), .init_ack(init_ack),
        .wait_mode(wait_mode), .bus_clk_off(bus_clk_off), .timer_en(timer_en),
        .wake_en(wake_en), .sleep_req(sleep_req), .init_req(init_req)
    );

    // monitor: pops the scoreboard on every read strobe
    always @(negedge clk) begin
        if (bus_sel && bus_rd) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL unexpected read: actual %02h expected none", rd_data);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (rd_data !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %02h expected %02h", t, rd_data, e);
                end
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_write(logic [7:0] d);
        bus_sel = 1; bus_wr = 1; wr_data = d;
        tick(1);
        bus_sel = 0; bus_wr = 0; wr_data = '0;
    endtask

    task automatic do_read(logic [7:0] e, string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_sel = 1; bus_rd = 1;
        tick(1);
        bus_sel = 0; bus_rd = 0;
    endtask

    task automatic check_bit(logic a, logic e, string t);
        n_cmp++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", t, a, e);
        end
    endtask

    initial begin
        #(20 * 5000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        do_read(8'h00, "R1 reset value");
        check_bit(bus_clk_off, 1'b0, "R1 clk_off after reset");
        @(negedge clk);
        check_bit(rd_data == 8'h00, 1'b1, "R11 no strobe reads zero");
        tick(1);

        // R2 set and stick
        rx_frame_ok = 1; tick(1); rx_frame_ok = 0;
        tick(2);
        do_read(8'h80, "R2 flag set and sticky");
        // R3 write 0 ignored, write 1 clears
        do_write(8'h00);
        do_read(8'h80, "R3 write zero ignored");
        do_write(8'h80);
        do_read(8'h00, "R3 write one clears");
        // R3 set beats clear
        rx_frame_ok = 1; do_write(8'h80); rx_frame_ok = 0;
        do_read(8'h80, "R3 set wins over clear");
        do_write(8'h80);

        // R4 status mirrors, writes ignored
        eng_rx_busy = 1; eng_synced = 1;
        do_write(8'h50);
        do_read(8'h50, "R4 status bits follow inputs");
        eng_rx_busy = 0;
        do_read(8'h10, "R4 rx busy drop");
        eng_synced = 0;

        // R5 loopback
        loopback = 1; eng_rx_busy = 1;
        rx_frame_ok = 1; tick(2); rx_frame_ok = 0;
        do_read(8'h00, "R5 loopback blocks flag and busy");
        loopback = 0; eng_rx_busy = 0;

        // R10 clock-off
        do_write(8'h20);
        wait_mode = 1; #1;
        check_bit(bus_clk_off, 1'b1, "R10 clk_off on");
        wait_mode = 0; #1;
        check_bit(bus_clk_off, 1'b0, "R10 clk_off wait low");
        do_write(8'h00); wait_mode = 1; #1;
        check_bit(bus_clk_off, 1'b0, "R10 clk_off stop-in-wait low");
        wait_mode = 0;

        // R6/R7/R8 init handshake
        rx_frame_ok = 1; tick(1); rx_frame_ok = 0;
        eng_synced = 1; eng_rx_busy = 1;
        do_write(8'h2E);
        do_read(8'hFE, "R11 full byte layout");
        do_write(8'h2F);
        tick(2);
        do_read(8'hFF, "R6 PEND not locked");
        check_bit(timer_en, 1'b1, "R6 timer on in PEND");
        init_ack = 1;
        tick(2);
        do_read(8'h07, "R7 held bits read zero in HELD");
        check_bit(timer_en, 1'b0, "R7 timer forced low");
        do_write(8'hF9);
        do_read(8'h07, "R8 writes ignored except init");
        do_write(8'h04);
        tick(1);
        do_read(8'h06, "R8 init req writable, LEAVE still locked");
        init_ack = 0;
        tick(2);
        do_read(8'h56, "R9 back in RUN, held bits cleared");
        do_write(8'h28);
        do_read(8'h78, "R9 writable again");
        check_bit(wake_en, 1'b0, "R9 wake cleared by write");

        eng_synced = 0; eng_rx_busy = 0;
        tick(3);
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard drain: actual %0d expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule